// File: doc/BRIEF.md
# Flat Panel Blank Color Selector

This block chooses the pixel index that a flat-panel video path hands to its palette stage. It either passes the incoming index through or puts a programmable default color index in its place. Because the choice is made before palette lookup and before frame-rate-control dithering, the substituted value is an index and not an RGB triple. The block also applies the two power-saving overrides, which act on the panel data pins rather than on the index.

The screen-blank condition is derived inside the block from the display-mode controls. In the emulation modes, the sequencer screen-off bit blanks the screen. In the CGA and Hercules modes, a cleared video-enable bit in the mode-control register blanks it. While blanked, every pixel becomes the default color. While not blanked, a separate enable lets the default color fill the flat-panel blank interval. Panel-off power saving forces the pins low or high, or releases them. Standby always releases them. The result is registered, with one clock of latency.

Top module: `fp_blank_sel`

## Requirements
- R1: While rst_ni is low, pix_o is 0 and oe_o is 0.
- R2: With no override active, pix_o equals the pix_i value sampled on the previous rising clock edge and oe_o is 1. Every control input is sampled on that same edge, so all outputs have one cycle of latency.
- R3: When mode_i is 2'b00 (emulation) or 2'b11 (reserved, handled as emulation) and seq_off_i is 1, the screen is blanked. vid_en_i has no effect in these modes.
- R4: When mode_i is 2'b01 (CGA) or 2'b10 (Hercules), the screen is blanked when vid_en_i is 0. seq_off_i has no effect in these modes.
- R5: While the screen is blanked, pix_o equals dflt_i and oe_o is 1, whatever the values of sub_en_i and fp_blank_i.
- R6: While the screen is not blanked, pix_o equals dflt_i only when sub_en_i and fp_blank_i are both 1. When sub_en_i is 0, pix_i passes through during the blank interval.
- R7: When panel_off_i is 1 and standby_i is 0, off_drv_i selects the output: 2'b00 gives pix_o all zeros with oe_o 1, 2'b01 gives pix_o all ones with oe_o 1, and 2'b10 or 2'b11 gives oe_o 0 with pix_o 0. This holds over blank and over substitution.
- R8: When standby_i is 1, oe_o is 0 and pix_o is 0, whatever panel_off_i and all other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | PIX_W (8) | Incoming pixel index |
| dflt_i | input | PIX_W (8) | Default color index |
| mode_i | input | 2 | Display mode: 00 emulation, 01 CGA, 10 Hercules, 11 reserved |
| seq_off_i | input | 1 | Sequencer screen-off bit |
| vid_en_i | input | 1 | Mode-control video-enable bit (CGA/Hercules) |
| fp_blank_i | input | 1 | Flat-panel blank interval flag |
| sub_en_i | input | 1 | Enable for default-color fill during the blank interval |
| panel_off_i | input | 1 | Panel-off power saving active |
| off_drv_i | input | 2 | Pin behaviour in panel-off: 00 low, 01 high, 1x released |
| standby_i | input | 1 | Standby power saving active |
| pix_o | output | PIX_W (8) | Registered pixel index toward the palette and pins |
| oe_o | output | 1 | Output enable for the panel data pins |

## Verification
The block's only state is its output register, so an error in the mode decode or the priority order shows up on pix_o or oe_o exactly one cycle after the input combination that triggers it. The reference model computes both outputs for every input combination and compares them on every clock. A wrong blank decode shows a pixel where the default color belongs, or the reverse. A wrong priority shows the default color, or a driven value, where the pins should be released. Directed sweeps cover each mode and each drive code, and a long pseudo-random run reaches the mixed-priority cases.

// File: rtl/fp_blank_pkg.sv
package fp_blank_pkg;
  typedef enum logic [1:0] {
    MODE_EMU  = 2'b00,
    MODE_CGA  = 2'b01,
    MODE_HERC = 2'b10,
    MODE_RSVD = 2'b11
  } disp_mode_e;

  typedef enum logic [1:0] {
    DRV_LOW  = 2'b00,
    DRV_HIGH = 2'b01,
    DRV_HIZ  = 2'b10,
    DRV_HIZ2 = 2'b11
  } off_drv_e;

  typedef enum logic [2:0] {
    SEL_PIX  = 3'd0,
    SEL_DFLT = 3'd1,
    SEL_LOW  = 3'd2,
    SEL_HIGH = 3'd3,
    SEL_HIZ  = 3'd4
  } out_sel_e;
endpackage

// File: rtl/fp_blank_detect.sv
module fp_blank_detect
  import fp_blank_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic       seq_off_i,
  input  logic       vid_en_i,
  output logic       blank_o
);
  disp_mode_e mode;
  assign mode = disp_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      MODE_CGA, MODE_HERC: blank_o = ~vid_en_i;
      default:             blank_o = seq_off_i;  // emulation and reserved
    endcase
  end
endmodule

// File: rtl/fp_out_prio.sv
module fp_out_prio
  import fp_blank_pkg::*;
(
  input  logic       standby_i,
  input  logic       panel_off_i,
  input  logic [1:0] off_drv_i,
  input  logic       blank_i,
  input  logic       fp_blank_i,
  input  logic       sub_en_i,
  output out_sel_e   sel_o
);
  off_drv_e drv;
  assign drv = off_drv_e'(off_drv_i);

  always_comb begin
    if (standby_i) begin
      sel_o = SEL_HIZ;
    end else if (panel_off_i) begin
      unique case (drv)
        DRV_LOW:  sel_o = SEL_LOW;
        DRV_HIGH: sel_o = SEL_HIGH;
        default:  sel_o = SEL_HIZ;
      endcase
    end else if (blank_i || (sub_en_i && fp_blank_i)) begin
      sel_o = SEL_DFLT;
    end else begin
      sel_o = SEL_PIX;
    end
  end
endmodule

// File: rtl/fp_out_mux.sv
module fp_out_mux
  import fp_blank_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  out_sel_e         sel_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] dflt_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             oe_o
);
  always_comb begin
    oe_o  = 1'b1;
    pix_o = pix_i;
    unique case (sel_i)
      SEL_DFLT: pix_o = dflt_i;
      SEL_LOW:  pix_o = '0;
      SEL_HIGH: pix_o = '1;
      SEL_HIZ: begin
        pix_o = '0;
        oe_o  = 1'b0;
      end
      default:  pix_o = pix_i;
    endcase
  end
endmodule

// File: rtl/fp_blank_sel.sv
module fp_blank_sel
  import fp_blank_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] dflt_i,
  input  logic [1:0]       mode_i,
  input  logic             seq_off_i,
  input  logic             vid_en_i,
  input  logic             fp_blank_i,
  input  logic             sub_en_i,
  input  logic             panel_off_i,
  input  logic [1:0]       off_drv_i,
  input  logic             standby_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             oe_o
);
  logic             blank;
  out_sel_e         sel;
  logic [PIX_W-1:0] pix_nxt;
  logic             oe_nxt;

  fp_blank_detect u_detect (
    .mode_i    (mode_i),
    .seq_off_i (seq_off_i),
    .vid_en_i  (vid_en_i),
    .blank_o   (blank)
  );

  fp_out_prio u_prio (
    .standby_i   (standby_i),
    .panel_off_i (panel_off_i),
    .off_drv_i   (off_drv_i),
    .blank_i     (blank),
    .fp_blank_i  (fp_blank_i),
    .sub_en_i    (sub_en_i),
    .sel_o       (sel)
  );

  fp_out_mux #(.PIX_W(PIX_W)) u_mux (
    .sel_i  (sel),
    .pix_i  (pix_i),
    .dflt_i (dflt_i),
    .pix_o  (pix_nxt),
    .oe_o   (oe_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o <= '0;
      oe_o  <= 1'b0;
    end else begin
      pix_o <= pix_nxt;
      oe_o  <= oe_nxt;
    end
  end

  a_r8_standby_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (!oe_o && pix_o == '0));

  a_r7_off_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && panel_off_i && off_drv_i == 2'b01) |=> (oe_o && pix_o == '1));

  a_r7_off_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && panel_off_i && off_drv_i[1]) |=> !oe_o);

  a_r5_blank_dflt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !panel_off_i && blank) |=> (oe_o && pix_o == $past(dflt_i)));

  a_r2_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!standby_i && !panel_off_i && !blank && !(sub_en_i && fp_blank_i))
      |=> (oe_o && pix_o == $past(pix_i)));

  a_r4_cga_seq_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {2'b01, 2'b10} && vid_en_i) |-> !blank);

  a_r3_emu_vid_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i inside {2'b00, 2'b11}) |-> (blank == seq_off_i));
endmodule

// File: tb/fp_blank_sel_tb.sv
module fp_blank_sel_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [PIX_W-1:0] pix_i = '0, dflt_i = '0;
  logic [1:0]       mode_i = '0, off_drv_i = '0;
  logic             seq_off_i = 0, vid_en_i = 1, fp_blank_i = 0, sub_en_i = 0;
  logic             panel_off_i = 0, standby_i = 0;
  logic [PIX_W-1:0] pix_o;
  logic             oe_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_blank_sel #(.PIX_W(PIX_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pix_i(pix_i), .dflt_i(dflt_i),
    .mode_i(mode_i), .seq_off_i(seq_off_i), .vid_en_i(vid_en_i),
    .fp_blank_i(fp_blank_i), .sub_en_i(sub_en_i), .panel_off_i(panel_off_i),
    .off_drv_i(off_drv_i), .standby_i(standby_i), .pix_o(pix_o), .oe_o(oe_o)
  );

  // behavioural reference: expected {oe, pix} and the requirement it follows
  logic [PIX_W:0] exp_q[$];
  string          tag_q[$];

  task automatic predict();
    bit blk;
    logic [PIX_W:0] e;
    string t;
    if (mode_i == 2'b01 || mode_i == 2'b10) blk = !vid_en_i;
    else blk = seq_off_i;
    if (standby_i) begin e = {1'b0, {PIX_W{1'b0}}}; t = "R8"; end
    else if (panel_off_i) begin
      t = "R7";
      if (off_drv_i == 2'b00) e = {1'b1, {PIX_W{1'b0}}};
      else if (off_drv_i == 2'b01) e = {1'b1, {PIX_W{1'b1}}};
      else e = {1'b0, {PIX_W{1'b0}}};
    end else if (blk) begin
      e = {1'b1, dflt_i};
      t = (mode_i == 2'b01 || mode_i == 2'b10) ? "R4/R5" : "R3/R5";
    end else if (sub_en_i && fp_blank_i) begin e = {1'b1, dflt_i}; t = "R6"; end
    else begin
      e = {1'b1, pix_i};
      t = (fp_blank_i) ? "R6" : "R2";
    end
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  task automatic tick();
    logic [PIX_W:0] e;
    string t;
    predict();
    @(negedge clk);
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    total++;
    if ({oe_o, pix_o} !== e) begin
      bad++;
      $display("FAIL %s: got oe=%0b pix=%02h expected oe=%0b pix=%02h",
               t, oe_o, pix_o, e[PIX_W], e[PIX_W-1:0]);
    end
  endtask

  task automatic set_all(input logic [7:0] p, input logic [7:0] d, input logic [1:0] m,
                         input bit so, input bit ve, input bit fb, input bit se,
                         input bit po, input logic [1:0] dr, input bit sb);
    pix_i = p; dflt_i = d; mode_i = m; seq_off_i = so; vid_en_i = ve;
    fp_blank_i = fb; sub_en_i = se; panel_off_i = po; off_drv_i = dr; standby_i = sb;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got hung expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1 reset state, with inputs asking for a driven value
    set_all(8'h5A, 8'h33, 2'b00, 0, 1, 0, 0, 1, 2'b01, 0);
    repeat (3) @(negedge clk);
    total++;
    if (pix_o !== '0 || oe_o !== 1'b0) begin
      bad++;
      $display("FAIL R1: got oe=%0b pix=%02h expected oe=0 pix=00", oe_o, pix_o);
    end
    rst_ni = 1'b1;

    // R2 pass-through with varying pixels
    for (int i = 0; i < 16; i++) begin
      set_all(8'(i * 17 + 3), 8'hC4, 2'(i % 4), 0, 1, 0, i[0], 0, 2'b00, 0);
      tick();
    end
    // R3 emulation / reserved blank, vid_en ignored
    for (int i = 0; i < 8; i++) begin
      set_all(8'(i + 8'h40), 8'h9E, i[0] ? 2'b11 : 2'b00, i[1], i[2], i[0], i[1], 0, 2'b00, 0);
      tick();
    end
    // R4 CGA / Hercules blank, seq_off ignored
    for (int i = 0; i < 8; i++) begin
      set_all(8'(i + 8'h80), 8'h21, i[0] ? 2'b10 : 2'b01, i[1], i[2], i[1], i[0], 0, 2'b00, 0);
      tick();
    end
    // R5 blanked regardless of sub_en / fp_blank
    for (int i = 0; i < 4; i++) begin
      set_all(8'hE7, 8'(8'h10 + i), 2'b00, 1, 1, i[0], i[1], 0, 2'b00, 0);
      tick();
    end
    // R6 blank-interval substitution and its enable
    for (int i = 0; i < 4; i++) begin
      set_all(8'h6C, 8'hA5, 2'b01, 1, 1, i[0], i[1], 0, 2'b00, 0);
      tick();
    end
    // R7 every drive code, over blank and substitution
    for (int i = 0; i < 8; i++) begin
      set_all(8'h3C, 8'hC3, 2'b00, i[2], 1, 1, 1, 1, 2'(i), 0);
      tick();
    end
    // R8 standby over panel-off and blank
    for (int i = 0; i < 8; i++) begin
      set_all(8'hFF, 8'h77, 2'(i), i[0], i[1], 1, 1, i[2], 2'b01, 1);
      tick();
    end
    // back-to-back transitions, then a pseudo-random mix
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      set_all(r[7:0], r[15:8], r[17:16], r[18], r[19], r[20], r[21],
              r[22] & r[23], r[25:24], r[26] & r[27] & r[28]);
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule